// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core runs a reverse Polish instruction stream. Every operand lives on an internal operand stack with a depth counter. It fetches one instruction word per instruction from a synchronous instruction memory. When a literal push is decoded, it fetches the word that follows as the immediate value. It reads and writes a single-port synchronous data memory that is word addressed. The core starts at instruction address 0 when reset is released. It runs until it meets a halt instruction or a fault, and then shows this on its status outputs.

Arithmetic and logic instructions take the two entries at the top of the stack. The lower entry is the left operand. The result replaces the lower entry, so the stack shrinks by one. Two reversed variants, one for subtract and one for divide, swap the operands. A load replaces the top entry in place with the memory word at that address. A store takes both the value and the address off the stack. A short program of pushes, loads, an add and a store computes an assignment such as `x := y + z` and leaves the stack empty.

Each instruction takes a fixed number of cycles:
- Push and load take 4 cycles.
- All other instructions take 2 cycles.

Top module: `rpn_core`

## Requirements
- R1: While reset is held and on its release, `halted`, `error`, `dmem_en` and `dmem_we` are 0 and `imem_addr` is 0. Execution begins at instruction address 0.
- R2: Push (opcode 1) takes the next instruction word as a 16-bit immediate and adds it as a new top entry. It takes 4 cycles.
- R3: Load (opcode 2) replaces the top entry with the data memory word at the address given by its low 8 bits. The depth does not change. It takes 4 cycles and makes one read.
- R4: Store (opcode 3) writes the top entry to the address held in the entry below it and removes both. It takes 2 cycles. The single write cycle (`dmem_en` and `dmem_we` both high) comes in the cycle after the decode cycle.
- R5: Add (4), subtract (5), multiply (7, low 16 bits), bitwise and (A) and bitwise or (B) compute lower op top, modulo 2^16. The result replaces the lower entry and the depth falls by one. Each takes 2 cycles.
- R6: Reverse subtract (6) gives top minus lower, and reverse divide (9) gives top divided by lower. Both are otherwise handled as in R5.
- R7: Divide (8) gives lower divided by top, unsigned. When the divisor is zero, the result is 16'hFFFF, `error` is set and execution continues.
- R8: Compare (C) gives 1 when the two entries are equal and 0 otherwise, and is handled as in R5.
- R9: A push when the stack already holds 16 entries sets `error` and `halted` in its decode cycle.
- R10: A load on an empty stack, or a store or binary operation with fewer than two entries, sets `error` and `halted` in its decode cycle.
- R11: Halt (opcode 0) sets `halted` in its decode cycle. `halted` and `error` stay set until reset. No memory access is made while halted.
- R12: Opcodes D, E and F are illegal. They set `error` and `halted` in their decode cycle.
- R13: The opcode is bits [3:0] of the fetched word. Bits [15:4] of an instruction word have no effect.
- R14: The program push x, push y, load, push z, load, add, store, halt leaves memory[x] equal to y+z with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction word address (registered program counter) |
| imem_rdata | input | 16 | Instruction word, one cycle after the address |
| dmem_en | output | 1 | Data memory access enable |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 8 | Data memory word address |
| dmem_wdata | output | 16 | Data memory write data |
| dmem_rdata | input | 16 | Data memory read data, one cycle after the enabled address |
| halted | output | 1 | Execution has stopped |
| error | output | 1 | Sticky fault flag |

## Verification
On every cycle, the embedded assertions check the following:
- The depth counter stays within bounds.
- A push grows the stack by one.
- A store or binary operation shrinks it by two or one.
- A write never happens without an access enable.
- The halt and error flags never clear.
- Memory stays quiet once halted.

Only the bench's programs can show the arithmetic results, including the reversed operand order, compare and divide by zero. The same holds for the exact cycle at which each fault appears, the address and data of every write, and the final memory image after the assignment program. The bench gets these by comparing against a behavioural model on every clock.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  localparam logic [3:0] OPC_HALT  = 4'h0;
  localparam logic [3:0] OPC_PUSH  = 4'h1;
  localparam logic [3:0] OPC_LOAD  = 4'h2;
  localparam logic [3:0] OPC_STORE = 4'h3;
  localparam logic [3:0] OPC_ADD   = 4'h4;
  localparam logic [3:0] OPC_SUB   = 4'h5;
  localparam logic [3:0] OPC_RSUB  = 4'h6;
  localparam logic [3:0] OPC_MUL   = 4'h7;
  localparam logic [3:0] OPC_DIV   = 4'h8;
  localparam logic [3:0] OPC_RDIV  = 4'h9;
  localparam logic [3:0] OPC_AND   = 4'hA;
  localparam logic [3:0] OPC_OR    = 4'hB;
  localparam logic [3:0] OPC_CMP   = 4'hC;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_IWAIT,
    ST_IMM,
    ST_MWAIT,
    ST_MRD,
    ST_HALT
  } core_state_e;

  typedef struct packed {
    logic       halt;
    logic       push;
    logic       load;
    logic       store;
    logic       binop;
    logic       illegal;
    logic [1:0] need;     // entries that must be present
  } op_class_t;

endpackage

// File: rtl/rpn_decode.sv
module rpn_decode
  import rpn_pkg::*;
(
  input  logic [3:0] opc,
  output op_class_t  cls
);

  always_comb begin
    cls = '0;
    case (opc)
      OPC_HALT:  cls.halt = 1'b1;
      OPC_PUSH:  cls.push = 1'b1;
      OPC_LOAD: begin
        cls.load = 1'b1;
        cls.need = 2'd1;
      end
      OPC_STORE: begin
        cls.store = 1'b1;
        cls.need  = 2'd2;
      end
      OPC_ADD, OPC_SUB, OPC_RSUB, OPC_MUL, OPC_DIV,
      OPC_RDIV, OPC_AND, OPC_OR, OPC_CMP: begin
        cls.binop = 1'b1;
        cls.need  = 2'd2;
      end
      default:   cls.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/rpn_alu.sv
module rpn_alu
  import rpn_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] lower,
  input  logic [W-1:0] upper,
  output logic [W-1:0] res,
  output logic         div_zero
);

  logic         swap;
  logic [W-1:0] lhs;
  logic [W-1:0] rhs;

  // reversed forms exchange the operands ahead of one shared datapath
  assign swap = (op == OPC_RSUB) || (op == OPC_RDIV);
  assign lhs  = swap ? upper : lower;
  assign rhs  = swap ? lower : upper;

  always_comb begin
    res      = '0;
    div_zero = 1'b0;
    case (op)
      OPC_ADD:            res = lhs + rhs;
      OPC_SUB, OPC_RSUB:  res = lhs - rhs;
      OPC_MUL:            res = lhs * rhs;
      OPC_DIV, OPC_RDIV: begin
        if (rhs == '0) begin
          res      = '1;
          div_zero = 1'b1;
        end else begin
          res = lhs / rhs;
        end
      end
      OPC_AND:            res = lhs & rhs;
      OPC_OR:             res = lhs | rhs;
      OPC_CMP:            res = {{(W-1){1'b0}}, (lhs == rhs)};
      default:            res = '0;
    endcase
  end

endmodule

// File: rtl/rpn_stack.sv
module rpn_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr_top,
  input  logic [IDX_W-1:0] raddr_sec,
  output logic [W-1:0]     rdata_top,
  output logic [W-1:0]     rdata_sec
);

  // one write port, two asynchronous read ports: maps onto distributed RAM
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_top = mem[raddr_top];
  assign rdata_sec = mem[raddr_sec];

endmodule

// File: rtl/rpn_core.sv
module rpn_core
  import rpn_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 16,
  parameter int PC_W        = 8,
  parameter int DADDR_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [DATA_W-1:0]  imem_rdata,
  output logic               dmem_en,
  output logic               dmem_we,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               halted,
  output logic               error
);

  localparam int IDX_W = $clog2(STACK_DEPTH);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STACK_DEPTH);

  core_state_e      st;
  logic [PC_W-1:0]  pc;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_m1;
  logic [CNT_W-1:0] cnt_m2;
  logic [IDX_W-1:0] idx_top;
  logic [IDX_W-1:0] idx_sec;

  op_class_t        cls;
  logic             depth_ok;
  logic             fault;

  logic             stk_we;
  logic [IDX_W-1:0] stk_waddr;
  logic [DATA_W-1:0] stk_wdata;
  logic [DATA_W-1:0] top_w;
  logic [DATA_W-1:0] sec_w;

  logic [DATA_W-1:0] alu_res;
  logic              alu_dz;

  assign imem_addr = pc;
  assign cnt_m1    = cnt - CNT_W'(1);
  assign cnt_m2    = cnt - CNT_W'(2);
  assign idx_top   = cnt_m1[IDX_W-1:0];
  assign idx_sec   = cnt_m2[IDX_W-1:0];

  rpn_decode u_dec (
    .opc (imem_rdata[3:0]),
    .cls (cls)
  );

  rpn_stack #(.DEPTH(STACK_DEPTH), .W(DATA_W)) u_stk (
    .clk       (clk),
    .we        (stk_we),
    .waddr     (stk_waddr),
    .wdata     (stk_wdata),
    .raddr_top (idx_top),
    .raddr_sec (idx_sec),
    .rdata_top (top_w),
    .rdata_sec (sec_w)
  );

  rpn_alu #(.W(DATA_W)) u_alu (
    .op       (imem_rdata[3:0]),
    .lower    (sec_w),
    .upper    (top_w),
    .res      (alu_res),
    .div_zero (alu_dz)
  );

  // depth checks for the instruction being decoded
  assign depth_ok = (cnt >= CNT_W'(cls.need)) && !(cls.push && (cnt == CNT_FULL));
  assign fault    = cls.illegal || !depth_ok;

  always_comb begin
    stk_we    = 1'b0;
    stk_waddr = idx_top;
    stk_wdata = alu_res;
    case (st)
      ST_DECODE: begin
        if (cls.binop && !fault) begin
          stk_we    = 1'b1;
          stk_waddr = idx_sec;
          stk_wdata = alu_res;
        end
      end
      ST_IMM: begin
        stk_we    = 1'b1;
        stk_waddr = cnt[IDX_W-1:0];
        stk_wdata = imem_rdata;
      end
      ST_MRD: begin
        stk_we    = 1'b1;
        stk_waddr = idx_top;
        stk_wdata = dmem_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_FETCH;
      pc         <= '0;
      cnt        <= '0;
      halted     <= 1'b0;
      error      <= 1'b0;
      dmem_en    <= 1'b0;
      dmem_we    <= 1'b0;
      dmem_addr  <= '0;
      dmem_wdata <= '0;
    end else begin
      dmem_en <= 1'b0;
      dmem_we <= 1'b0;
      case (st)
        ST_FETCH: st <= ST_DECODE;
        ST_DECODE: begin
          if (cls.halt || fault) begin
            halted <= 1'b1;
            if (fault) error <= 1'b1;
            st <= ST_HALT;
          end else begin
            pc <= pc + PC_W'(1);
            if (cls.push) begin
              st <= ST_IWAIT;
            end else if (cls.load) begin
              dmem_en   <= 1'b1;
              dmem_addr <= top_w[DADDR_W-1:0];
              st        <= ST_MWAIT;
            end else if (cls.store) begin
              dmem_en    <= 1'b1;
              dmem_we    <= 1'b1;
              dmem_addr  <= sec_w[DADDR_W-1:0];
              dmem_wdata <= top_w;
              cnt        <= cnt_m2;
              st         <= ST_FETCH;
            end else begin
              cnt <= cnt_m1;
              if (alu_dz) error <= 1'b1;
              st <= ST_FETCH;
            end
          end
        end
        ST_IWAIT: st <= ST_IMM;
        ST_IMM: begin
          cnt <= cnt + CNT_W'(1);
          pc  <= pc + PC_W'(1);
          st  <= ST_FETCH;
        end
        ST_MWAIT: st <= ST_MRD;
        ST_MRD:   st <= ST_FETCH;
        default:  st <= ST_HALT;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);

  p_push_grow_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IMM) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_load_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MRD) |=> $stable(cnt));

  p_store_shrink_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && cls.store && !fault) |=>
      (dmem_we && dmem_en && cnt == $past(cnt) - CNT_W'(2)));

  p_we_has_en_r4: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> dmem_en);

  p_binop_shrink_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && cls.binop && !fault) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dmem_en);

endmodule

// File: tb/tb_rpn_core.sv
`timescale 1ns/1ps
module tb_rpn_core;

  localparam int NEVER = 1 << 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic        dmem_en, dmem_we;
  logic [7:0]  dmem_addr;
  logic [15:0] dmem_wdata;
  logic [15:0] dmem_rdata;
  logic        halted, error;

  always #2 clk = ~clk;

  rpn_core dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_en(dmem_en), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .halted(halted), .error(error)
  );

  logic [15:0] rom [256];
  logic [15:0] ram [256];
  logic [15:0] mref [256];

  always @(posedge clk) imem_rdata <= rom[imem_addr];
  always @(posedge clk) begin
    if (dmem_en) begin
      if (dmem_we) ram[dmem_addr] <= dmem_wdata;
      dmem_rdata <= ram[dmem_addr];
    end
  end

  int c;
  always @(posedge clk) begin
    if (rst) c <= 0;
    else     c <= c + 1;
  end

  int checks = 0;
  int fails  = 0;
  int ip;
  int halt_e, err_e;
  int wq_a[$], wq_d[$], wq_c[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic emit(input logic [15:0] w);
    rom[ip[7:0]] = w;
    ip++;
  endtask

  task automatic lit(input logic [15:0] v);
    emit(16'h0001);
    emit(v);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 256; i++) begin
      rom[i] = 16'h0000;
      ram[i] = 16'(i * 3 + 1);
    end
    ip = 0;
  endtask

  // behavioural reference: stack as a queue, timing from per-instruction cycle counts
  task automatic model();
    logic [15:0] stk[$];
    logic [15:0] iw, s, tp, r;
    logic [3:0]  op;
    int pc, t, d, steps;
    bit stop, bad;
    halt_e = NEVER; err_e = NEVER;
    wq_a.delete(); wq_d.delete(); wq_c.delete();
    for (int i = 0; i < 256; i++) mref[i] = ram[i];
    pc = 0; t = 0; stop = 0; steps = 0;
    while (!stop && steps < 1000) begin
      steps++;
      iw = rom[pc[7:0]]; op = iw[3:0]; d = t + 2; bad = 0;
      if (op == 4'h0) begin
        halt_e = d; stop = 1;
      end else if (op == 4'h1) begin
        if (stk.size() >= 16) bad = 1;
        else begin stk.push_back(rom[8'(pc + 1)]); pc += 2; t += 4; end
      end else if (op == 4'h2) begin
        if (stk.size() < 1) bad = 1;
        else begin
          stk[stk.size()-1] = mref[stk[stk.size()-1][7:0]];
          pc += 1; t += 4;
        end
      end else if (op == 4'h3) begin
        if (stk.size() < 2) bad = 1;
        else begin
          tp = stk.pop_back(); s = stk.pop_back();
          mref[s[7:0]] = tp;
          wq_a.push_back(int'(s[7:0])); wq_d.push_back(int'(tp)); wq_c.push_back(d);
          pc += 1; t += 2;
        end
      end else if (op <= 4'hC) begin
        if (stk.size() < 2) bad = 1;
        else begin
          tp = stk.pop_back(); s = stk.pop_back();
          case (op)
            4'h4: r = s + tp;
            4'h5: r = s - tp;
            4'h6: r = tp - s;
            4'h7: r = 16'(s * tp);
            4'h8: r = (tp == 0) ? 16'hFFFF : s / tp;
            4'h9: r = (s == 0) ? 16'hFFFF : tp / s;
            4'hA: r = s & tp;
            4'hB: r = s | tp;
            default: r = (s == tp) ? 16'd1 : 16'd0;
          endcase
          if (((op == 4'h8 && tp == 0) || (op == 4'h9 && s == 0)) && err_e > d) err_e = d;
          stk.push_back(r);
          pc += 1; t += 2;
        end
      end else begin
        bad = 1;
      end
      if (bad) begin
        halt_e = d;
        if (err_e > d) err_e = d;
        stop = 1;
      end
    end
  endtask

  task automatic run(input string tag);
    int n;
    model();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!halted && !error && !dmem_en && !dmem_we && imem_addr == 8'd0, "R1",
          "reset outputs", {halted, error, dmem_en, dmem_we}, 0);
    rst = 1'b0;
    n = 0;
    while (c < halt_e + 3 && n < 3000) begin
      @(negedge clk);
      n++;
      check(halted == (c >= halt_e), tag, $sformatf("halted at cycle %0d", c),
            int'(halted), int'(c >= halt_e));
      check(error == (c >= err_e), tag, $sformatf("error at cycle %0d", c),
            int'(error), int'(c >= err_e));
      if (c >= halt_e)
        check(!dmem_en, "R11", "memory access while halted", int'(dmem_en), 0);
      if (dmem_we) begin
        if (wq_a.size() == 0) begin
          check(0, "R4", "unexpected write", int'(dmem_addr), -1);
        end else begin
          check(int'(dmem_addr) == wq_a[0] && int'(dmem_wdata) == wq_d[0] && c == wq_c[0],
                "R4", $sformatf("write addr/data/cycle %0d", c),
                int'({dmem_addr, dmem_wdata}), (wq_a[0] << 16) | wq_d[0]);
          void'(wq_a.pop_front()); void'(wq_d.pop_front()); void'(wq_c.pop_front());
        end
      end
    end
    // watchdog
    check(n < 3000, tag, "watchdog expired", n, 3000);
    check(wq_a.size() == 0, "R4", "missing writes", wq_a.size(), 0);
    for (int i = 0; i < 256; i++)
      if (ram[i] !== mref[i])
        check(0, tag, $sformatf("memory word %0d", i), int'(ram[i]), int'(mref[i]));
    checks++;
  endtask

  initial begin
    // R14 and R13: assignment program with junk in upper instruction bits
    clear_all();
    ram[21] = 16'd7; ram[22] = 16'd35;
    lit(16'd20); lit(16'd21); emit(16'h5A02); lit(16'd22); emit(16'h0002);
    emit(16'hFF04); emit(16'h0003); emit(16'h7770);
    run("R14 R13 R3");
    check(ram[20] == 16'd42, "R14", "x := y + z", int'(ram[20]), 42);
    check(!error, "R14", "no error", int'(error), 0);

    // R5 R6 R7 R8: each operation stores its result at 40+k
    clear_all();
    lit(16'd40); lit(16'd1000);   lit(16'd234);    emit(16'h0004); emit(16'h0003);
    lit(16'd41); lit(16'd50);     lit(16'd80);     emit(16'h0005); emit(16'h0003);
    lit(16'd42); lit(16'd50);     lit(16'd80);     emit(16'h0006); emit(16'h0003);
    lit(16'd43); lit(16'd300);    lit(16'd300);    emit(16'h0007); emit(16'h0003);
    lit(16'd44); lit(16'd100);    lit(16'd7);      emit(16'h0008); emit(16'h0003);
    lit(16'd45); lit(16'd7);      lit(16'd100);    emit(16'h0009); emit(16'h0003);
    lit(16'd46); lit(16'd5);      lit(16'd0);      emit(16'h0008); emit(16'h0003);
    lit(16'd47); lit(16'hF0F0);   lit(16'hFF00);   emit(16'h000A); emit(16'h0003);
    lit(16'd48); lit(16'hF0F0);   lit(16'h0F01);   emit(16'h000B); emit(16'h0003);
    lit(16'd49); lit(16'd9);      lit(16'd9);      emit(16'h000C); emit(16'h0003);
    lit(16'd50); lit(16'd9);      lit(16'd8);      emit(16'h000C); emit(16'h0003);
    emit(16'h0000);
    run("R5 R6 R7 R8");
    check(ram[40] == 16'd1234,  "R5", "add",   int'(ram[40]), 1234);
    check(ram[41] == 16'hFFE2,  "R5", "sub wraps", int'(ram[41]), 'hFFE2);
    check(ram[42] == 16'd30,    "R6", "reverse subtract", int'(ram[42]), 30);
    check(ram[43] == 16'd24464, "R5", "multiply low half", int'(ram[43]), 24464);
    check(ram[44] == 16'd14,    "R7", "divide", int'(ram[44]), 14);
    check(ram[45] == 16'd14,    "R6", "reverse divide", int'(ram[45]), 14);
    check(ram[46] == 16'hFFFF,  "R7", "divide by zero", int'(ram[46]), 'hFFFF);
    check(ram[50] == 16'd0 && ram[49] == 16'd1, "R8", "compare", int'({ram[49][7:0], ram[50][7:0]}), 'h0100);
    check(error && halted, "R7", "error set, ran to halt", int'({error, halted}), 3);

    // R9: seventeenth push overflows
    clear_all();
    for (int k = 0; k < 17; k++) lit(16'(k + 100));
    emit(16'h0000);
    run("R9");

    // R10: binary op with one entry
    clear_all();
    lit(16'd1); emit(16'h0004); emit(16'h0000);
    run("R10");

    // R10: load on empty stack
    clear_all();
    emit(16'h0002); emit(16'h0000);
    run("R10");

    // R10: store with one entry, must not write
    clear_all();
    lit(16'd5); emit(16'h0003); emit(16'h0000);
    run("R10");

    // R12: illegal opcode
    clear_all();
    lit(16'd3); emit(16'h000E); lit(16'd4);
    run("R12");

    // R11 and R13: halt with upper bits set
    clear_all();
    emit(16'h1230); lit(16'd9);
    run("R11 R13");
    check(halted && !error, "R11", "halt only", int'({halted, error}), 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule